// File: doc/BRIEF.md
# Power Operational Mode Sequencer

This block steers an auxiliary low-power subsystem between four operating modes. Software writes a 2-bit mode target into a request register. The sequencer accepts only a target that is one step away along the fixed chain powerdown-wake-to-active, active, lowpower, powerdown-wake-to-lowpower. It then raises the supply-state and clock-select outputs for the new mode and waits for the supply handshake. When the handshake arrives it copies the target into a read-only acknowledge register. Software treats the acknowledged value as the mode in force and does not issue a new target until the acknowledge matches the request.

An external wakeup flag lifts the subsystem out of either powerdown mode for as long as the flag is held. In the mode that wakes to active, the outputs behave as in active mode. In the mode that wakes to lowpower, they behave as in lowpower mode. A write that skips a step in the chain, or that arrives while a step is still pending, changes nothing and sets a sticky error flag.

The controller has two named states. SETTLED means the request equals the acknowledge. STEPPING means a step has been accepted and is waiting for the supply. There are three transitions. ACCEPT takes SETTLED to STEPPING on an adjacent target. SETTLE takes STEPPING back to SETTLED when the supply is ready. HOLD keeps the current state for every other case, including rejected writes.

Top module: `opmode_seq`

## Requirements
- R1: After reset the request, acknowledge and error registers read 0, `supply_pd_req` is 0, `clk_sel` is 0 and `eff_mode` is 0.
- R2: Mode codes are: 0 active, 1 lowpower, 2 powerdown waking to active, 3 powerdown waking to lowpower. `clk_sel` codes are: 0 active source, 1 medium-frequency clock, 2 powerdown source. With the wakeup flag low, the outputs follow the request register. Mode 0 gives `supply_pd_req`=0 and `clk_sel`=0. Mode 1 gives 1 and 1. Modes 2 and 3 give 1 and 2. `eff_mode` equals the request.
- R3: In SETTLED, a write to the request register with a value that neighbours the acknowledge in the chain 2-0-1-3 is loaded into the request on the next clock edge, and the controller enters STEPPING (ACCEPT).
- R4: In STEPPING, the acknowledge takes the request value on the first rising edge at which `supply_ready` is 1, and the controller returns to SETTLED (SETTLE). While `supply_ready` stays 0, the acknowledge does not change.
- R5: In SETTLED, a write with a value that does not neighbour the acknowledge leaves the request unchanged and sets the error flag.
- R6: Any write to the request register during STEPPING leaves the request unchanged and sets the error flag.
- R7: A write of the value already acknowledged, while SETTLED, changes nothing and does not set the error flag.
- R8: The error flag stays set until a write to the error register with bit 0 set clears it. A write with bit 0 clear has no effect on it.
- R9: With the wakeup flag high, request 2 drives the outputs as mode 0 and request 3 drives them as mode 1, and `eff_mode` shows 0 or 1 respectively. Requests 0 and 1 ignore the flag.
- R10: The request register is at byte offset 0x0, bits 1:0, read/write. The acknowledge register is at 0x4, bits 1:0, read-only; writes to it are ignored. The error register is at 0x8, bit 0. All other bits read 0 and ignore writes, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| supply_ready | input | 1 | Supply handshake completing a pending step |
| wake_flag | input | 1 | External wakeup flag |
| supply_pd_req | output | 1 | 1 requests the powerdown supply state, 0 the active state |
| clk_sel | output | 2 | Clock-rate select for the effective mode |
| eff_mode | output | 2 | Effective mode after the wakeup override |

## Verification
A table walks the request through the chain in both directions. It mixes accepted neighbour steps with skip attempts, such as 3 to 0 and 1 to 2, which separates a correct adjacency test from one that only compares codes numerically or wraps at the chain ends. Directed runs then cover several situations:
- holding the supply handshake low, which shows that the acknowledge waits;
- writing during a pending step and writing the current mode, which separate the two reject reasons from a harmless no-op;
- raising the wakeup flag in each of the four modes, which shows that only the powerdown modes are overridden and each to its own target;
- writing all-ones data and writing the acknowledge offset, which expose any stray bits or writable read-only fields.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    typedef enum logic [1:0] {
        MODE_ACT   = 2'd0,
        MODE_LP    = 2'd1,
        MODE_PD_WA = 2'd2,
        MODE_PD_WL = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CLK_ACTIVE = 2'd0,
        CLK_MF     = 2'd1,
        CLK_PD     = 2'd2
    } clksel_e;

    typedef enum logic {
        ST_SETTLED  = 1'b0,
        ST_STEPPING = 1'b1
    } seq_state_e;

    // Position of a mode along the chain 2-0-1-3.
    function automatic logic [1:0] chain_pos(input logic [1:0] m);
        logic [1:0] p;
        unique case (m)
            2'd2:    p = 2'd0;
            2'd0:    p = 2'd1;
            2'd1:    p = 2'd2;
            default: p = 2'd3;
        endcase
        return p;
    endfunction

    function automatic logic is_neighbour(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] pa;
        logic [2:0] pb;
        pa = {1'b0, chain_pos(a)};
        pb = {1'b0, chain_pos(b)};
        return (pa == pb + 3'd1) || (pb == pa + 3'd1);
    endfunction

endpackage

// File: rtl/opmode_chain.sv
module opmode_chain (
    input  logic [1:0] cur_mode,
    input  logic [1:0] tgt_mode,
    output logic       adjacent,
    output logic       same
);
    import opmode_pkg::*;

    always_comb begin
        adjacent = is_neighbour(cur_mode, tgt_mode);
        same     = (cur_mode == tgt_mode);
    end
endmodule

// File: rtl/opmode_decode.sv
module opmode_decode (
    input  logic [1:0] mode,
    input  logic       wake,
    output logic [1:0] eff_mode,
    output logic       supply_pd,
    output logic [1:0] clk_sel
);
    import opmode_pkg::*;

    mode_e eff;

    always_comb begin
        eff = mode_e'(mode);
        if (mode == MODE_PD_WA && wake) begin
            eff = MODE_ACT;
        end else if (mode == MODE_PD_WL && wake) begin
            eff = MODE_LP;
        end
    end

    always_comb begin
        eff_mode = eff;
        unique case (eff)
            MODE_ACT: begin
                supply_pd = 1'b0;
                clk_sel   = CLK_ACTIVE;
            end
            MODE_LP: begin
                supply_pd = 1'b1;
                clk_sel   = CLK_MF;
            end
            default: begin
                supply_pd = 1'b1;
                clk_sel   = CLK_PD;
            end
        endcase
    end
endmodule

// File: rtl/opmode_regif.sv
module opmode_regif #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int REQ_OFF = 0,
    parameter int ACK_OFF = 4,
    parameter int ERR_OFF = 8
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        req_val,
    input  logic [1:0]        ack_val,
    input  logic              err_val,
    output logic              wr_req,
    output logic              wr_err_clr,
    output logic [1:0]        new_mode,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(REQ_OFF);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(ACK_OFF);
    localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(ERR_OFF);
    localparam int PAD_MODE = DATA_W - 2;
    localparam int PAD_ERR  = DATA_W - 1;

    always_comb begin
        wr_req     = bus_we && (bus_addr == A_REQ);
        wr_err_clr = bus_we && (bus_addr == A_ERR) && bus_wdata[0];
        new_mode   = bus_wdata[1:0];
    end

    always_comb begin
        if (bus_addr == A_REQ) begin
            bus_rdata = {{PAD_MODE{1'b0}}, req_val};
        end else if (bus_addr == A_ACK) begin
            bus_rdata = {{PAD_MODE{1'b0}}, ack_val};
        end else if (bus_addr == A_ERR) begin
            bus_rdata = {{PAD_ERR{1'b0}}, err_val};
        end else begin
            bus_rdata = '0;
        end
    end
endmodule

// File: rtl/opmode_seq.sv
module opmode_seq #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int REQ_OFF = 0,
    parameter int ACK_OFF = 4,
    parameter int ERR_OFF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              supply_ready,
    input  logic              wake_flag,
    output logic              supply_pd_req,
    output logic [1:0]        clk_sel,
    output logic [1:0]        eff_mode
);
    import opmode_pkg::*;

    seq_state_e state_q, state_d;
    logic [1:0] req_q, req_d;
    logic [1:0] ack_q, ack_d;
    logic       err_q, err_d;

    logic       wr_req;
    logic       wr_err_clr;
    logic [1:0] new_mode;
    logic       adjacent;
    logic       same;

    opmode_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REQ_OFF(REQ_OFF),
        .ACK_OFF(ACK_OFF),
        .ERR_OFF(ERR_OFF)
    ) u_regif (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req_val   (req_q),
        .ack_val   (ack_q),
        .err_val   (err_q),
        .wr_req    (wr_req),
        .wr_err_clr(wr_err_clr),
        .new_mode  (new_mode),
        .bus_rdata (bus_rdata)
    );

    opmode_chain u_chain (
        .cur_mode(ack_q),
        .tgt_mode(new_mode),
        .adjacent(adjacent),
        .same    (same)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLED;
            req_q   <= MODE_ACT;
            ack_q   <= MODE_ACT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
            ack_q   <= ack_d;
            err_q   <= err_d;
        end
    end

    // Transitions: ACCEPT, SETTLE, HOLD
    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        ack_d   = ack_q;
        err_d   = err_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (wr_req && !same) begin
                    if (adjacent) begin
                        req_d   = new_mode;
                        state_d = ST_STEPPING;
                    end else begin
                        err_d = 1'b1;
                    end
                end
            end
            ST_STEPPING: begin
                if (wr_req) begin
                    err_d = 1'b1;
                end
                if (supply_ready) begin
                    ack_d   = req_q;
                    state_d = ST_SETTLED;
                end
            end
            default: state_d = ST_SETTLED;
        endcase
        if (wr_err_clr) begin
            err_d = 1'b0;
        end
    end

    // Outputs
    opmode_decode u_decode (
        .mode     (req_q),
        .wake     (wake_flag),
        .eff_mode (eff_mode),
        .supply_pd(supply_pd_req),
        .clk_sel  (clk_sel)
    );
endmodule

// File: rtl/opmode_seq_chk.sv
module opmode_seq_chk #(
    parameter int ADDR_W  = 4,
    parameter int REQ_OFF = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              supply_ready,
    input logic              wake_flag,
    input logic [1:0]        req,
    input logic [1:0]        ack,
    input logic              err,
    input logic              supply_pd_req,
    input logic [1:0]        clk_sel
);
    import opmode_pkg::*;

    assert_ack_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != $past(ack)) |-> $past(supply_ready));

    assert_req_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req != $past(req)) |-> ($past(req) == $past(ack) && is_neighbour($past(ack), req)));

    assert_req_near_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == ack) || is_neighbour(ack, req));

    assert_wake_to_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req == MODE_PD_WA && wake_flag) |-> (!supply_pd_req && clk_sel == CLK_ACTIVE));

    assert_lowpower_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == MODE_LP) |-> (supply_pd_req && clk_sel == CLK_MF));

    assert_err_from_req_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(bus_we) && $past(bus_addr) == ADDR_W'(REQ_OFF)));
endmodule

bind opmode_seq opmode_seq_chk #(.ADDR_W(ADDR_W), .REQ_OFF(REQ_OFF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .supply_ready (supply_ready),
    .wake_flag    (wake_flag),
    .req          (req_q),
    .ack          (ack_q),
    .err          (err_q),
    .supply_pd_req(supply_pd_req),
    .clk_sel      (clk_sel)
);

// File: tb/tb_opmode_seq.sv
module tb_opmode_seq;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_REQ = 4'h0;
    localparam logic [ADDR_W-1:0] A_ACK = 4'h4;
    localparam logic [ADDR_W-1:0] A_ERR = 4'h8;
    localparam logic [ADDR_W-1:0] A_BAD = 4'hC;

    // {target mode[1:0], accepted}
    localparam int NVEC = 11;
    localparam logic [2:0] VEC [NVEC] = '{
        {2'd1, 1'b1}, {2'd3, 1'b1}, {2'd0, 1'b0}, {2'd1, 1'b1},
        {2'd2, 1'b0}, {2'd0, 1'b1}, {2'd2, 1'b1}, {2'd3, 1'b0},
        {2'd0, 1'b1}, {2'd1, 1'b1}, {2'd0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              supply_ready = 1'b0;
    logic              wake_flag = 1'b0;
    logic              supply_pd_req;
    logic [1:0]        clk_sel;
    logic [1:0]        eff_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] model;

    always #2.5 clk = ~clk;

    opmode_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .supply_ready (supply_ready),
        .wake_flag    (wake_flag),
        .supply_pd_req(supply_pd_req),
        .clk_sel      (clk_sel),
        .eff_mode     (eff_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ready_pulse();
        @(negedge clk);
        supply_ready = 1'b1;
        @(negedge clk);
        supply_ready = 1'b0;
    endtask

    function automatic logic [3:0] exp_out(input logic [1:0] m);
        // {supply_pd, clk_sel, unused}
        case (m)
            2'd0:    return {1'b0, 2'd0, 1'b0};
            2'd1:    return {1'b1, 2'd1, 1'b0};
            default: return {1'b1, 2'd2, 1'b0};
        endcase
    endfunction

    task automatic check_outs(input string tag, input logic [1:0] m, input logic [1:0] em);
        logic [3:0] e;
        e = exp_out(m);
        check({tag, " pd"}, {31'd0, supply_pd_req}, {31'd0, e[3]});
        check({tag, " clk"}, {30'd0, clk_sel}, {30'd0, e[2:1]});
        check({tag, " eff"}, {30'd0, eff_mode}, {30'd0, em});
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_REQ, r); check("R1 req", r, 0);
        rd(A_ACK, r); check("R1 ack", r, 0);
        rd(A_ERR, r); check("R1 err", r, 0);
        check_outs("R1", 2'd0, 2'd0);

        // Table walk: R2 R3 R4 R5
        model = 2'd0;
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] tgt;
            tgt = VEC[i][2:1];
            wr(A_REQ, {30'd0, tgt});
            if (VEC[i][0]) model = tgt;
            rd(A_REQ, r); check("R3 req after write", r, {30'd0, model});
            rd(A_ERR, r); check("R5 err after write", r, {31'd0, !VEC[i][0]});
            check_outs("R2", model, model);
            ready_pulse();
            rd(A_ACK, r); check("R4 ack after ready", r, {30'd0, model});
            wr(A_ERR, 32'h1);
        end

        // R4: acknowledge waits for ready
        wr(A_REQ, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_ACK, r); check("R4 ack held", r, 0);
        // R6: write while stepping
        wr(A_REQ, 32'h0);
        rd(A_REQ, r); check("R6 req unchanged", r, 1);
        rd(A_ERR, r); check("R6 err set", r, 1);
        ready_pulse();
        rd(A_ACK, r); check("R4 ack settled", r, 1);

        // R8: sticky, write 0 no effect, write 1 clears
        wr(A_ERR, 32'h0);
        rd(A_ERR, r); check("R8 err sticky", r, 1);
        wr(A_ERR, 32'h1);
        rd(A_ERR, r); check("R8 err cleared", r, 0);

        // R7: write current mode
        wr(A_REQ, 32'h1);
        rd(A_REQ, r); check("R7 req same", r, 1);
        rd(A_ERR, r); check("R7 no err", r, 0);
        rd(A_ACK, r); check("R7 ack same", r, 1);

        // R9: mode 1 ignores wake
        wake_flag = 1'b1; #1;
        check_outs("R9 mode1 wake", 2'd1, 2'd1);
        wake_flag = 1'b0;
        wr(A_REQ, 32'h3); ready_pulse();
        wake_flag = 1'b1; #1;
        check_outs("R9 mode3 wake", 2'd1, 2'd1);
        wake_flag = 1'b0; #1;
        check_outs("R9 mode3 idle", 2'd3, 2'd3);
        wr(A_REQ, 32'h1); ready_pulse();
        wr(A_REQ, 32'h0); ready_pulse();
        wake_flag = 1'b1; #1;
        check_outs("R9 mode0 wake", 2'd0, 2'd0);
        wake_flag = 1'b0;
        wr(A_REQ, 32'h2); ready_pulse();
        wake_flag = 1'b1; #1;
        check_outs("R9 mode2 wake", 2'd0, 2'd0);
        wake_flag = 1'b0; #1;
        check_outs("R9 mode2 idle", 2'd2, 2'd2);

        // R10: register map
        wr(A_ACK, 32'h3);
        rd(A_ACK, r); check("R10 ack read-only", r, 2);
        rd(A_ERR, r); check("R10 ack write no err", r, 0);
        wr(A_REQ, 32'hFFFF_FFF0);
        rd(A_REQ, r); check("R10 req upper zero", r, 0);
        ready_pulse();
        rd(A_ACK, r); check("R10 ack after step", r, 0);
        wr(A_REQ, 32'h3);
        wr(A_ERR, 32'hFFFF_FFFE);
        rd(A_ERR, r); check("R10 err bit0 only", r, 1);
        rd(A_BAD, r); check("R10 unmapped", r, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule